// File: doc/BRIEF.md
# Timed Parameter Word Sequencer

This block sits on the read side of a first-word-fall-through FIFO that a processor keeps filled with parameter entries. After a start command it replays the entries on a 48-bit output word port, one entry at a time. Each word is held for an exact number of clock cycles taken from the entry, and the block never switches faster than every second cycle. A run-control state machine handles start, stop, suspend and resume commands, and accepts suspend and stop requests from external inputs too. A per-channel start offset delays the first word by a fixed number of cycles, so several channels can be skewed against each other by a constant amount.

Each 64-bit FIFO entry is laid out as follows. Bits 47:0 hold the output payload. Bits 62:48 hold the hold count in cycles. Bit 63 marks the first word of a two-word frequency set. A gradient update is a single entry with bit 63 clear, and its 10-bit gradient address sits in the low payload bits. The output driver is always enabled, so a separate valid flag tells when the word is meaningful. If the FIFO runs dry when the next word is due, the block stops and raises a sticky underrun flag.

Top module: `param_word_seq`

## Requirements
- R1: While reset is held, and after it is released with no command given, o_valid, o_fifo_rd, o_pair_head, o_pair_tail and o_underrun are all low.
- R2: Entries leave the FIFO in order. For each one, bits 47:0 appear unchanged on o_word with o_valid high, and one FIFO read is made per word.
- R3: A word is held on o_word for exactly the number of cycles given in entry bits 62:48 (a count of 2 or more).
- R4: A hold count of 0 or 1 is treated as 2, so no word is shown for fewer than two cycles.
- R5: The first word becomes valid i_offset+1 cycles after the clock edge that samples i_start in the idle or stopped state. With an offset of 0 this is one cycle. o_valid stays low during the offset wait.
- R6: o_pair_head equals bit 63 of the entry currently shown. o_pair_tail is high on a word that directly follows a head word within the same unbroken valid run, and is low otherwise.
- R7: i_suspend or i_ext_suspend, seen while running, freezes o_word, o_valid and the remaining hold count. After i_resume the word continues for its remaining cycles, so its total hold grows by the number of edges from the suspending edge to the resuming edge, both counted.
- R8: i_stop or i_ext_stop, seen in the offset-wait, running or suspended state, drops o_valid at that edge and makes no further FIFO read. A later i_start replays from the next unread entry, with o_pair_tail low on the first word.
- R9: When a word is due and i_fifo_empty is high, o_valid drops at that edge, o_underrun rises and the block stops. o_underrun stays high until an accepted i_start clears it.
- R10: o_fifo_rd is never asserted while i_fifo_empty is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, one word slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_start | input | 1 | Start command, accepted in idle or stopped state |
| i_stop | input | 1 | Stop command |
| i_suspend | input | 1 | Suspend command |
| i_resume | input | 1 | Resume command, leaves the suspended state |
| i_ext_suspend | input | 1 | External manual suspend request |
| i_ext_stop | input | 1 | External manual stop request |
| i_offset | input | OFFSET_W (30) | Start offset in cycles, sampled with i_start |
| i_fifo_empty | input | 1 | FIFO has no entry |
| i_fifo_data | input | WORD_W+HOLD_W+1 (64) | Head entry of the FIFO (fall-through) |
| o_fifo_rd | output | 1 | Pop the head entry at this edge |
| o_word | output | WORD_W (48) | Output parameter word |
| o_valid | output | 1 | o_word carries a live word |
| o_pair_head | output | 1 | Current word opens a two-word frequency set |
| o_pair_tail | output | 1 | Current word follows a head word |
| o_underrun | output | 1 | Sticky FIFO underrun flag |

## Verification
The in-line assertions check on every cycle the properties that hold at each edge. They check that no two FIFO reads are back to back, which enforces the two-cycle minimum. They check that no read is made from an empty FIFO, that a stop or underrun clears valid and lands in the stopped state, that valid stays low while waiting out the offset, that a suspended word does not move, and that the underrun flag is sticky. The exact hold length of each word, the clamp of short counts, the start latency for a given offset, the stretch a suspend adds, the pair tagging across runs and the resumption from the next unread entry after a stop span many cycles and depend on the FIFO contents. Only the scoreboard scenarios can show these.

// File: rtl/pws_pkg.sv
package pws_pkg;

  // Run-control states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DELAY = 3'd1,
    ST_RUN   = 3'd2,
    ST_SUSP  = 3'd3,
    ST_STOP  = 3'd4
  } run_st_e;

  // Shortest time any word may stay on the output, in cycles
  localparam int unsigned MIN_HOLD = 2;

  // Hold count actually applied to an entry's raw count field
  function automatic int unsigned eff_hold(input int unsigned raw);
    return (raw < MIN_HOLD) ? MIN_HOLD : raw;
  endfunction

endpackage

// File: rtl/pws_ctrl.sv
module pws_ctrl
  import pws_pkg::*;
#(
  parameter int OFFSET_W = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                susp_i,
  input  logic                resume_i,
  input  logic [OFFSET_W-1:0] offset_i,
  input  logic                underrun_evt_i,
  output run_st_e             state_o,
  output logic                run_go_o,
  output logic                kill_o,
  output logic                underrun_o
);

  run_st_e             st_q, st_d;
  logic [OFFSET_W-1:0] dly_q, dly_d;
  logic                active;
  logic                start_ok;
  logic                delay_done;
  logic                underrun_q;

  assign active     = (st_q == ST_DELAY) || (st_q == ST_RUN) || (st_q == ST_SUSP);
  assign kill_o     = active && stop_i;
  assign start_ok   = ((st_q == ST_IDLE) || (st_q == ST_STOP)) && start_i;
  assign run_go_o   = (st_q == ST_RUN) && !stop_i && !susp_i;
  assign delay_done = (dly_q == OFFSET_W'(1));

  always_comb begin
    st_d  = st_q;
    dly_d = dly_q;
    case (st_q)
      ST_IDLE, ST_STOP: begin
        if (start_i) begin
          if (offset_i == '0) begin
            st_d = ST_RUN;
          end else begin
            st_d  = ST_DELAY;
            dly_d = offset_i;
          end
        end
      end
      ST_DELAY: begin
        if (stop_i) begin
          st_d = ST_STOP;
        end else begin
          dly_d = dly_q - OFFSET_W'(1);
          if (delay_done) st_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (stop_i || underrun_evt_i) st_d = ST_STOP;
        else if (susp_i)              st_d = ST_SUSP;
      end
      ST_SUSP: begin
        if (stop_i)        st_d = ST_STOP;
        else if (resume_i) st_d = ST_RUN;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      dly_q      <= '0;
      underrun_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      dly_q <= dly_d;
      if (start_ok)            underrun_q <= 1'b0;
      else if (underrun_evt_i) underrun_q <= 1'b1;
    end
  end

  assign state_o    = st_q;
  assign underrun_o = underrun_q;

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_q && !start_ok) |=> underrun_q);                          // R9
  AST_UNDERRUN_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt_i |=> (st_q == ST_STOP));                             // R9
  AST_STOP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    kill_o |=> (st_q == ST_STOP));                                     // R8

endmodule

// File: rtl/pws_player.sv
module pws_player
  import pws_pkg::*;
#(
  parameter int WORD_W = 48,
  parameter int HOLD_W = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_go_i,
  input  logic                     kill_i,
  input  logic                     fifo_empty_i,
  input  logic [WORD_W+HOLD_W:0]   fifo_data_i,
  output logic                     fifo_rd_o,
  output logic                     underrun_evt_o,
  output logic                     load_evt_o,
  output logic [WORD_W-1:0]        word_o,
  output logic                     valid_o,
  output logic                     head_o,
  output logic                     tail_o
);

  localparam int ENTRY_W  = WORD_W + HOLD_W + 1;
  localparam int HOLD_LSB = WORD_W;
  localparam int HEAD_BIT = ENTRY_W - 1;

  logic [HOLD_W-1:0] rem_q;
  logic [HOLD_W-1:0] hold_f;
  logic [HOLD_W-1:0] first_rem;
  logic              load_due;
  logic [WORD_W-1:0] word_q;
  logic              valid_q, head_q, tail_q;

  assign hold_f    = fifo_data_i[HOLD_LSB +: HOLD_W];
  assign first_rem = HOLD_W'(eff_hold(32'(hold_f)) - 1);

  // A new word is due once the current one has used up its hold
  assign load_due       = run_go_i && (rem_q == '0);
  assign fifo_rd_o      = load_due && !fifo_empty_i;
  assign underrun_evt_o = load_due && fifo_empty_i;
  assign load_evt_o     = fifo_rd_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      head_q  <= 1'b0;
      tail_q  <= 1'b0;
      rem_q   <= '0;
    end else if (kill_i || underrun_evt_o) begin
      valid_q <= 1'b0;
      head_q  <= 1'b0;
      tail_q  <= 1'b0;
      rem_q   <= '0;
    end else if (fifo_rd_o) begin
      word_q  <= fifo_data_i[WORD_W-1:0];
      head_q  <= fifo_data_i[HEAD_BIT];
      tail_q  <= valid_q && head_q;
      valid_q <= 1'b1;
      rem_q   <= first_rem;
    end else if (run_go_i && (rem_q != '0)) begin
      rem_q <= rem_q - HOLD_W'(1);
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign head_o  = head_q;
  assign tail_o  = tail_q;

  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt_o |=> !load_evt_o);                                       // R4
  AST_READ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_o |-> !fifo_empty_i);                                      // R10
  AST_HALT_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_i || underrun_evt_o) |=> !valid_q);                          // R8

endmodule

// File: rtl/param_word_seq.sv
module param_word_seq
  import pws_pkg::*;
#(
  parameter int WORD_W   = 48,
  parameter int HOLD_W   = 15,
  parameter int OFFSET_W = 30
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     i_start,
  input  logic                     i_stop,
  input  logic                     i_suspend,
  input  logic                     i_resume,
  input  logic                     i_ext_suspend,
  input  logic                     i_ext_stop,
  input  logic [OFFSET_W-1:0]      i_offset,
  input  logic                     i_fifo_empty,
  input  logic [WORD_W+HOLD_W:0]   i_fifo_data,
  output logic                     o_fifo_rd,
  output logic [WORD_W-1:0]        o_word,
  output logic                     o_valid,
  output logic                     o_pair_head,
  output logic                     o_pair_tail,
  output logic                     o_underrun
);

  logic    stop_any, susp_any;
  run_st_e state;
  logic    run_go, kill, underrun_evt, load_evt;

  assign stop_any = i_stop | i_ext_stop;
  assign susp_any = i_suspend | i_ext_suspend;

  pws_ctrl #(.OFFSET_W(OFFSET_W)) ctrl_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (i_start),
    .stop_i         (stop_any),
    .susp_i         (susp_any),
    .resume_i       (i_resume),
    .offset_i       (i_offset),
    .underrun_evt_i (underrun_evt),
    .state_o        (state),
    .run_go_o       (run_go),
    .kill_o         (kill),
    .underrun_o     (o_underrun)
  );

  pws_player #(.WORD_W(WORD_W), .HOLD_W(HOLD_W)) player_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .run_go_i       (run_go),
    .kill_i         (kill),
    .fifo_empty_i   (i_fifo_empty),
    .fifo_data_i    (i_fifo_data),
    .fifo_rd_o      (o_fifo_rd),
    .underrun_evt_o (underrun_evt),
    .load_evt_o     (load_evt),
    .word_o         (o_word),
    .valid_o        (o_valid),
    .head_o         (o_pair_head),
    .tail_o         (o_pair_tail)
  );

  AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSP) |=> ((state != ST_SUSP) || ($stable(o_word) && $stable(o_valid) && !load_evt))); // R7
  AST_DELAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DELAY) |-> (!o_valid && !o_fifo_rd));                // R5
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP) |-> (!o_valid && !o_fifo_rd));                 // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!o_valid && !o_underrun));                // R1

endmodule

// File: tb/param_word_seq_tb_top.sv
module param_word_seq_tb_top;

  localparam int WORD_W   = 48;
  localparam int HOLD_W   = 15;
  localparam int OFFSET_W = 30;
  localparam int ENTRY_W  = WORD_W + HOLD_W + 1;

  typedef struct {
    logic [WORD_W-1:0] word;
    logic              head;
    int                hold;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic i_start, i_stop, i_suspend, i_resume, i_ext_suspend, i_ext_stop;
  logic [OFFSET_W-1:0] i_offset;
  logic i_fifo_empty;
  logic [ENTRY_W-1:0] i_fifo_data;
  logic o_fifo_rd, o_valid, o_pair_head, o_pair_tail, o_underrun;
  logic [WORD_W-1:0] o_word;

  always #5 clk = ~clk;

  param_word_seq #(.WORD_W(WORD_W), .HOLD_W(HOLD_W), .OFFSET_W(OFFSET_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_stop(i_stop),
    .i_suspend(i_suspend), .i_resume(i_resume), .i_ext_suspend(i_ext_suspend),
    .i_ext_stop(i_ext_stop), .i_offset(i_offset), .i_fifo_empty(i_fifo_empty),
    .i_fifo_data(i_fifo_data), .o_fifo_rd(o_fifo_rd), .o_word(o_word),
    .o_valid(o_valid), .o_pair_head(o_pair_head), .o_pair_tail(o_pair_tail),
    .o_underrun(o_underrun)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [ENTRY_W-1:0] fq[$];
  exp_t exp_q[$];
  bit trunc_ok = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void fifo_refresh();
    i_fifo_empty = (fq.size() == 0);
    i_fifo_data  = (fq.size() == 0) ? '0 : fq[0];
  endfunction

  // FIFO model: the read strobe is sampled before the edge updates, then popped
  always @(posedge clk) begin
    automatic logic rd_s = o_fifo_rd;
    #1;
    if (rd_s && fq.size() != 0) void'(fq.pop_front());
    fifo_refresh();
  end

  // Driver: one FIFO entry plus its expected scoreboard item
  task automatic push(input logic [WORD_W-1:0] w, input int raw_hold,
                      input logic head, input int extra);
    exp_t e;
    fq.push_back({head, HOLD_W'(raw_hold), w});
    fifo_refresh();
    e.word = w;
    e.head = head;
    e.hold = ((raw_hold < 2) ? 2 : raw_hold) + extra;   // R4 clamp
    exp_q.push_back(e);
  endtask

  // Monitor / scoreboard
  logic              pv = 1'b0;
  logic              ph = 1'b0;
  logic [WORD_W-1:0] pw = '0;
  int                run_len = 0;
  int                cur_hold = 0;

  task automatic finish_run();
    if (!trunc_ok) chk("R3", "hold length", 64'(run_len), 64'(cur_hold));
    trunc_ok = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (o_valid && (!pv || o_word != pw)) begin
        if (pv) finish_run();
        if (exp_q.size() == 0) begin
          chk("R2", "unexpected word", 64'(o_word), 64'hDEAD);
        end else begin
          automatic exp_t e = exp_q.pop_front();
          chk("R2", "word", 64'(o_word), 64'(e.word));
          chk("R6", "pair head", 64'(o_pair_head), 64'(e.head));
          chk("R6", "pair tail", 64'(o_pair_tail), 64'(pv && ph));
          cur_hold = e.hold;
        end
        run_len = 1;
      end else if (o_valid) begin
        run_len++;
      end else if (pv) begin
        finish_run();
      end
      pv = o_valid;
      pw = o_word;
      ph = o_pair_head;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: i_start = 1'b1;
      1: i_stop = 1'b1;
      2: i_suspend = 1'b1;
      3: i_resume = 1'b1;
      4: i_ext_suspend = 1'b1;
      default: i_ext_stop = 1'b1;
    endcase
    @(negedge clk);
    i_start = 0; i_stop = 0; i_suspend = 0; i_resume = 0;
    i_ext_suspend = 0; i_ext_stop = 0;
  endtask

  task automatic wait_drop();
    while (o_valid) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 0;
    i_start = 0; i_stop = 0; i_suspend = 0; i_resume = 0;
    i_ext_suspend = 0; i_ext_stop = 0; i_offset = '0;
    fifo_refresh();
    tick(3);
    chk("R1", "valid in reset", 64'(o_valid), 0);
    chk("R1", "rd in reset", 64'(o_fifo_rd), 0);
    chk("R1", "underrun in reset", 64'(o_underrun), 0);
    rst_n = 1;
    tick(2);
    chk("R1", "valid after reset", 64'(o_valid), 0);
    chk("R1", "head/tail after reset", 64'({o_pair_head, o_pair_tail}), 0);

    // Basic stream, offset 0, with short counts and pair flags
    push(48'h1111, 3, 0, 0);
    push(48'h2222, 2, 1, 0);
    push(48'h3333, 0, 0, 0);   // R4: 0 -> 2
    push(48'h4444, 1, 1, 0);   // R4: 1 -> 2
    push(48'h5555, 5, 0, 0);
    push(48'h6666, 2, 0, 0);
    pulse(0);
    chk("R5", "valid one edge after start", 64'(o_valid), 0);
    tick(1);
    chk("R5", "first word after one cycle", 64'(o_valid), 1);
    wait_drop();
    chk("R9", "underrun on empty", 64'(o_underrun), 1);
    chk("R2", "fifo drained", 64'(fq.size()), 0);
    tick(5);
    chk("R9", "underrun sticky", 64'(o_underrun), 1);
    chk("R9", "valid low after underrun", 64'(o_valid), 0);

    // Start offset
    i_offset = 30'd7;
    push(48'h7777, 4, 0, 0);
    push(48'h8888, 2, 0, 0);
    pulse(0);
    chk("R9", "start clears underrun", 64'(o_underrun), 0);
    cnt = 1;
    while (!o_valid && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    chk("R5", "offset latency", 64'(cnt), 64'(7 + 2));
    wait_drop();

    // External suspend, command resume: gap of 3 negedges -> +4 cycles
    i_offset = '0;
    push(48'h9999, 6, 0, 4);
    push(48'hAAAA, 2, 1, 0);
    push(48'hBBBB, 3, 0, 0);
    pulse(0);
    tick(2);
    pulse(4);
    tick(2);
    chk("R7", "word frozen", 64'(o_word), 64'h9999);
    chk("R7", "valid held", 64'(o_valid), 1);
    pulse(3);
    wait_drop();

    // Command suspend, stop while suspended, restart from next entry
    push(48'hC001, 4, 0, 0);
    push(48'hC002, 3, 1, 0);
    push(48'hC003, 2, 0, 0);
    push(48'hC004, 2, 0, 0);
    pulse(0);
    tick(2);
    pulse(2);
    tick(2);
    chk("R7", "suspended word", 64'(o_word), 64'hC001);
    trunc_ok = 1;
    pulse(1);
    chk("R8", "valid drops on stop", 64'(o_valid), 0);
    tick(5);
    chk("R8", "no reads after stop", 64'(fq.size()), 3);
    chk("R8", "still stopped", 64'(o_valid), 0);
    pulse(0);
    tick(1);
    chk("R8", "restart word", 64'(o_word), 64'hC002);
    chk("R8", "restart tail low", 64'(o_pair_tail), 0);
    wait_drop();

    // External stop during the offset wait
    i_offset = 30'd10;
    push(48'hD001, 2, 0, 0);
    pulse(0);
    tick(3);
    pulse(5);
    tick(15);
    chk("R8", "ext stop in delay keeps valid low", 64'(o_valid), 0);
    chk("R8", "ext stop in delay keeps fifo", 64'(fq.size()), 1);
    i_offset = '0;
    pulse(0);
    tick(1);
    chk("R2", "entry kept after stop", 64'(o_word), 64'hD001);
    wait_drop();
    tick(3);
    chk("R2", "scoreboard empty", 64'(exp_q.size()), 0);

    summary();
    $finish;
  end

endmodule